// File: doc/BRIEF.md
# Three-Channel Residue-to-Binary Converter

This block turns a number held as three residues into an ordinary unsigned binary integer. The three moduli are m1 = 2^(2N+1)-1, m2 = 2^(2N) and m3 = 2^N-1, with N a parameter. These moduli are pairwise coprime, and the dynamic range is M = m1·m2·m3. It sits at the output of a residue-arithmetic datapath. The residues arrive on three buses of 2N+1, 2N and N bits, and the binary result leaves on a 5N+1 bit bus in the same cycle. The block holds no state and needs no clock.

The conversion rests on the Chinese Remainder Theorem and is built only from wiring and adders. The 2N low bits of the result are the power-of-two residue itself. The upper 3N+1 bits are a quotient Q = x3 - x2 + (2^N-1)·A, where A is a modulo-m1 combination of all three residues. A is formed by summing five rotated or inverted copies of the inputs in an end-around-carry carry-save tree, followed by a one's-complement adder. Q is then formed by a three-operand sum of rewired copies of A, x2 and x3, and that sum needs no multiplier.

No corrective addition is made. The result is exact for X in [0, M-(m2-1)^2). Above that bound the quotient wraps modulo 2^(3N+1), and the block does not correct it.

Top module: `rns_crt_converter`

## Requirements
- R1: The 2N least significant bits of `bin_out` always equal `res_pow2`.
- R2: For any X in [0, M-(m2-1)^2), driving the residues X mod m1, X mod m2 and X mod m3 makes `bin_out` equal X.
- R3: With all three residue inputs zero, `bin_out` is zero.
- R4: The two edges of the valid range convert exactly: X = 1 and X = M-(m2-1)^2-1 (1897214 for N=4).
- R5: On `res_big`, the all-ones pattern 2^(2N+1)-1 is a second code for zero. Any value X with X mod m1 = 0 gives the same `bin_out` whether `res_big` is driven with zero or with all ones.
- R6: A modulo-m1 intermediate that is congruent to zero is used as zero, even when the one's-complement adder yields the all-ones pattern. As a result, every X = k·m2 with 0 ≤ k < m3 converts exactly.
- R7: The top of the range is not corrected. The residues of X = M-1 give an all-ones `bin_out` (2^(5N+1)-1) and not M-1.
- R8: The block is combinational. A change of the residue inputs shows up on `bin_out` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| res_big | input | 2N+1 | Residue modulo 2^(2N+1)-1; all ones is accepted as zero |
| res_pow2 | input | 2N | Residue modulo 2^(2N) |
| res_small | input | N | Residue modulo 2^N-1 |
| bin_out | output | 5N+1 | Binary value: quotient in the upper 3N+1 bits, `res_pow2` below |

## Verification
Multiples of m2 keep the power-of-two residue at zero and drive the intermediate to zero, so they show whether the zero and all-ones forms of that intermediate are handled. Values just below m2 and at m2 exercise the x3 - x2 borrow in the quotient adder. The last valid value and M-1 tell a correct range bound apart from an accidental correction. Values that are multiples of m1, fed once with zero and once with all ones on the wide channel, separate the two zero codes. Pseudo-random values across the valid range catch a wrong rotation amount or a misplaced inversion in any of the five terms.

// File: rtl/rns_crt_pkg.sv
package rns_crt_pkg;

    // Default channel parameter: widths are 2N+1, 2N and N bits.
    parameter int unsigned RNS_N_DEF = 4;

    // Power of two as a 64-bit value, used by the checking arithmetic.
    function automatic logic [63:0] pow2(input int unsigned k);
        return 64'd1 << k;
    endfunction

    // Modulo reduction in 64-bit arithmetic, used by the checking arithmetic.
    function automatic logic [63:0] modr(input logic [63:0] v, input logic [63:0] m);
        return v % m;
    endfunction

endpackage

// File: rtl/rns_crt_terms.sv
module rns_crt_terms
    import rns_crt_pkg::*;
#(
    parameter int unsigned N = RNS_N_DEF
) (
    input  logic [2*N:0]           x1,
    input  logic [2*N-1:0]         x2,
    input  logic [N-1:0]           x3,
    output logic [4:0][2*N:0]      u
);
    localparam int unsigned W1 = 2 * N + 1;
    localparam logic [63:0] M1 = pow2(W1) - 64'd1;

    logic [W1-1:0] x2w;
    logic [63:0]   v1, v2, v3, e0, e1, e2, e3, e4;

    always_comb begin
        x2w  = {1'b0, x2};
        // -2^(N+2)*x1: rotate left by N+2, then invert
        u[0] = ~((x1 << (N + 2)) | (x1 >> (W1 - N - 2)));
        // -4*x1: rotate left by 2, then invert
        u[1] = ~((x1 << 2) | (x1 >> (W1 - 2)));
        // 2^(N+1)*x2: rotate left by N+1
        u[2] = (x2w << (N + 1)) | (x2w >> (W1 - N - 1));
        // 2*x2: fits without wrap
        u[3] = {x2, 1'b0};
        // 2^(N+1)*x3 + 2*x3: two copies of x3 side by side
        u[4] = {x3, x3, 1'b0};

        v1 = modr(64'(x1), M1);
        v2 = 64'(x2) % M1;
        v3 = 64'(x3);
        e0 = (M1 - modr(pow2(N + 2) * v1, M1)) % M1;
        e1 = (M1 - modr(64'd4 * v1, M1)) % M1;
        e2 = modr(pow2(N + 1) * v2, M1);
        e3 = modr(64'd2 * v2, M1);
        e4 = modr((pow2(N + 1) + 64'd2) * v3, M1);

        // R2
        term_mod_chk: assert (modr(64'(u[0]), M1) == e0 && modr(64'(u[1]), M1) == e1
                              && modr(64'(u[2]), M1) == e2 && modr(64'(u[3]), M1) == e3
                              && modr(64'(u[4]), M1) == e4)
            else $error("term congruence broken");
    end

endmodule

// File: rtl/rns_eac_csa.sv
module rns_eac_csa
    import rns_crt_pkg::*;
#(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    localparam logic [63:0] MW = pow2(W) - 64'd1;

    logic [W-1:0] maj;

    always_comb begin
        s   = a ^ b ^ c;
        maj = (a & b) | (a & c) | (b & c);
        // carries move up one place; the top carry wraps to bit 0
        cy  = {maj[W-2:0], maj[W-1]};

        // R2
        csa_mod_chk: assert (modr(64'(s) + 64'(cy), MW) == modr(64'(a) + 64'(b) + 64'(c), MW))
            else $error("carry-save congruence broken");
    end

endmodule

// File: rtl/rns_eac_cpa.sv
module rns_eac_cpa
    import rns_crt_pkg::*;
#(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam logic [63:0] MW = pow2(W) - 64'd1;

    logic [W:0]   raw;
    logic [W-1:0] fold;

    always_comb begin
        raw  = {1'b0, a} + {1'b0, b};
        fold = raw[W-1:0] + W'(raw[W]);
        // all ones is the second code for zero: hand zero on
        sum  = (fold == {W{1'b1}}) ? '0 : fold;

        // R6
        cpa_canon_chk: assert (64'(sum) == modr(64'(a) + 64'(b), MW))
            else $error("one's-complement sum not canonical");
    end

endmodule

// File: rtl/rns_quot_adder.sv
module rns_quot_adder
    import rns_crt_pkg::*;
#(
    parameter int unsigned N = RNS_N_DEF
) (
    input  logic [2*N:0]   a_val,
    input  logic [2*N-1:0] x2,
    input  logic [N-1:0]   x3,
    output logic [3*N:0]   q
);
    localparam int unsigned WQ = 3 * N + 1;
    localparam logic [63:0] QMASK = pow2(WQ) - 64'd1;

    logic [WQ-1:0] b1, b2, b3, s, cvec;
    logic [WQ-2:0] maj;
    logic [63:0]   expq;

    always_comb begin
        b1   = {{(N + 1){1'b1}}, ~x2};       // -x2 - 1
        b2   = {a_val, x3};                 // 2^N*A + x3
        b3   = {{N{1'b1}}, ~a_val};         // -A - 1
        s    = b1 ^ b2 ^ b3;
        maj  = (b1[WQ-2:0] & b2[WQ-2:0]) | (b1[WQ-2:0] & b3[WQ-2:0])
             | (b2[WQ-2:0] & b3[WQ-2:0]);
        // the empty bit 0 of the carry vector and the carry-in restore both -1 terms
        cvec = {maj, 1'b1};
        q    = s + cvec + WQ'(1);

        expq = (64'(x3) - 64'(x2) + (pow2(N) - 64'd1) * 64'(a_val)) & QMASK;
        // R2
        quot_sum_chk: assert (64'(q) == expq)
            else $error("quotient sum wrong");
    end

endmodule

// File: rtl/rns_crt_converter.sv
module rns_crt_converter
    import rns_crt_pkg::*;
#(
    parameter int unsigned N = RNS_N_DEF
) (
    input  logic [2*N:0]   res_big,
    input  logic [2*N-1:0] res_pow2,
    input  logic [N-1:0]   res_small,
    output logic [5*N:0]   bin_out
);
    localparam int unsigned W1 = 2 * N + 1;
    localparam int unsigned WQ = 3 * N + 1;
    localparam int unsigned NCSA = 3;
    localparam logic [63:0] M1 = pow2(W1) - 64'd1;

    logic [4:0][W1-1:0] u;
    logic [W1-1:0]      s_ch [NCSA+1];
    logic [W1-1:0]      c_ch [NCSA+1];
    logic [W1-1:0]      a_val;
    logic [WQ-1:0]      q;
    logic [63:0]        ka, kb, expa;

    rns_crt_terms #(.N(N)) u_terms (
        .x1 (res_big),
        .x2 (res_pow2),
        .x3 (res_small),
        .u  (u)
    );

    assign s_ch[0] = u[0];
    assign c_ch[0] = u[1];

    for (genvar i = 0; i < NCSA; i++) begin : g_csa
        rns_eac_csa #(.W(W1)) u_csa (
            .a  (s_ch[i]),
            .b  (c_ch[i]),
            .c  (u[i+2]),
            .s  (s_ch[i+1]),
            .cy (c_ch[i+1])
        );
    end

    rns_eac_cpa #(.W(W1)) u_cpa (
        .a   (s_ch[NCSA]),
        .b   (c_ch[NCSA]),
        .sum (a_val)
    );

    rns_quot_adder #(.N(N)) u_quot (
        .a_val (a_val),
        .x2    (res_pow2),
        .x3    (res_small),
        .q     (q)
    );

    always_comb begin
        bin_out = {q, res_pow2};

        ka   = M1 - modr(pow2(N + 2) + 64'd4, M1);
        kb   = pow2(N + 1) + 64'd2;
        expa = modr(ka * modr(64'(res_big), M1) + kb * 64'(res_pow2)
                    + kb * 64'(res_small), M1);
        // R6
        a_form_chk: assert (64'(a_val) == expa)
            else $error("stage-one value wrong");
    end

endmodule

// File: tb/rns_crt_converter_bench.sv
module rns_crt_converter_bench;

    localparam int unsigned N  = 4;
    localparam int unsigned W1 = 2 * N + 1;
    localparam int unsigned W2 = 2 * N;
    localparam int unsigned WX = 5 * N + 1;
    localparam longint M1 = (longint'(1) << W1) - 1;
    localparam longint M2 = longint'(1) << W2;
    localparam longint M3 = (longint'(1) << N) - 1;
    localparam longint MM = M1 * M2 * M3;
    localparam longint BOUND = MM - (M2 - 1) * (M2 - 1);
    localparam longint XMASK = (longint'(1) << WX) - 1;

    logic          clk;
    logic          rst_n;
    logic [W1-1:0] res_big;
    logic [W2-1:0] res_pow2;
    logic [N-1:0]  res_small;
    logic [WX-1:0] bin_out;

    int checks;
    int failures;
    int cycles;
    bit done;
    logic [31:0] rng;

    rns_crt_converter #(.N(N)) u_rns_crt_converter (
        .res_big   (res_big),
        .res_pow2  (res_pow2),
        .res_small (res_small),
        .bin_out   (bin_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic drive(input longint x);
        @(negedge clk);
        res_big   = W1'(x % M1);
        res_pow2  = W2'(x % M2);
        res_small = N'(x % M3);
        #1;
    endtask

    task automatic conv(input string req, input longint x);
        drive(x);
        check(req, longint'(bin_out), x);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R3 zero residues", longint'(bin_out), 0);
        conv("R3 X=0", 0);
    endtask

    task automatic t_edges;
        conv("R4 X=1", 1);
        conv("R4 last valid", BOUND - 1);
        conv("R2 X=m2-1", M2 - 1);
        conv("R2 X=m2", M2);
        conv("R2 X=m2+1", M2 + 1);
    endtask

    task automatic t_low_bits;
        for (int k = 0; k < 8; k++) begin
            longint x;
            x = (longint'(k) * 237_113 + 97) % BOUND;
            drive(x);
            check("R1 low bits", longint'(bin_out[W2-1:0]), x % M2);
        end
    endtask

    task automatic t_ones_zero;
        for (int k = 0; k < 6; k++) begin
            longint x;
            x = M1 * longint'(k * 511 + 3);
            drive(x);
            check("R5 zero code", longint'(bin_out), x);
            @(negedge clk);
            res_big = {W1{1'b1}};
            #1;
            check("R5 all-ones code", longint'(bin_out), x);
        end
    endtask

    task automatic t_zero_intermediate;
        for (int k = 0; k < int'(M3); k++) begin
            conv("R6 multiple of m2", M2 * longint'(k));
        end
    endtask

    task automatic t_top_wrap;
        drive(MM - 1);
        check("R7 uncorrected top", longint'(bin_out), XMASK);
    endtask

    task automatic t_no_clock;
        longint xa, xb;
        xa = 1234;
        xb = 777_777;
        drive(xa);
        res_big   = W1'(xb % M1);
        res_pow2  = W2'(xb % M2);
        res_small = N'(xb % M3);
        #1;
        check("R8 same-cycle update", longint'(bin_out), xb);
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            longint x;
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            x = longint'(rng) % BOUND;
            conv("R2 random", x);
        end
    endtask

    initial begin
        checks = 0;
        failures = 0;
        done = 1'b0;
        rng = 32'h1f2e3d4c;
        rst_n = 1'b0;
        res_big = '0;
        res_pow2 = '0;
        res_small = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_edges();
        t_low_bits();
        t_ones_zero();
        t_zero_intermediate();
        t_top_wrap();
        t_no_clock();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50_000 && !done) begin
                checks++;
                failures++;
                $display("FAIL watchdog got=%0d expected=%0d", cycles, 50_000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

endmodule